// File: doc/BRIEF.md
# Compact Register-Mapped Serial Port

A small asynchronous serial transmitter/receiver sitting behind a word-addressed register bus. The host writes bytes into an eight-entry transmit queue and pops received bytes from an eight-entry receive queue, both through one data register. Frames carry one start bit, seven or eight data bits sent least significant bit first, and one stop bit, with no parity. The bit time equals eight ticks of a programmable 16-bit divider, so the baud rate is the clock divided by eight times the divisor.

The register set follows the general shape of the classic 16550 layout, reduced to what this port needs. It has an interrupt enable and identify pair, word-length control, line status, a software-driven request-to-send pin, a readable clear-to-send pin, a scratch byte, separate receiver and transmitter enables, and the divisor. Only one interrupt cause is reported at a time, and receive data takes precedence. Writing the identify register flushes the queues. Bits with no function ignore writes and read as zero.

Top module: `lite_uart`

## Requirements
- R1: After reset the line status register (offset 5) reads 0x60, the identify register (offset 2) reads 0x01, txOut and rtsOut are 1 and 0, and irqOut is 0. Receiver, transmitter and all interrupt enables are off.
- R2: A byte written to offset 0 is sent on txOut as one low start bit, the data bits least significant first, and one high stop bit. Each bit lasts 8 x divisor clocks. When line control bits 1:0 (offset 3) equal 3 the frame has 8 data bits, and otherwise it has 7. txOut is high whenever no frame is in progress.
- R3: A frame received on rxIn is stored, and line status bit 0 then reads 1. A read of offset 0 returns it and removes it. In 7-bit mode bit 7 of the stored byte is 0. A read of offset 0 with the receive queue empty returns 0.
- R4: The transmit queue holds 8 bytes and sends them in order. Line status bit 5 is 1 while the queue has a free entry and 0 once 8 bytes are waiting.
- R5: A frame that completes while the receive queue holds 8 bytes is dropped, and line status bit 1 is set. The bit clears after the line status register is read. The 8 stored bytes are kept intact.
- R6: Identify register encoding is as follows. 0x04 means receive data is pending with receive interrupt enabled (IER bit 0). 0x02 means transmit space is available with transmit interrupt enabled (IER bit 1) and no receive cause. 0x01 means nothing is pending. Bits 1 and 2 are never both set.
- R7: irqOut is 1 only when a cause from R6 is pending and IER bits 2 and 3 are both 1.
- R8: A write to offset 2 with bit 1 set empties the receive queue, and with bit 2 set empties the transmit queue. Flushed bytes are never delivered.
- R9: Line status bit 6 is 1 only when the transmit queue is empty and no frame is being shifted out.
- R10: Offset 7 stores and returns 8 bits. Offset 4 bit 1 drives rtsOut. Offset 6 bit 5 shows ctsIn, seen through a two-flop synchroniser. IER reads back only bits 3:0, line control reads back only bits 1:0, and offset 4 reads back only bit 1.
- R11: Offset 8 bit 0 enables the receiver and bit 1 enables the transmitter. With the receiver off, incoming frames are ignored. With the transmitter off, queued bytes stay queued and txOut stays high.
- R12: Offset 10 holds the 16-bit divisor and reads back as written. A divisor of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 4 | Register word address |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops data, clears overrun) |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for regAddr, valid in the same cycle |
| rxIn | input | 1 | Serial receive line |
| txOut | output | 1 | Serial transmit line |
| ctsIn | input | 1 | Clear-to-send input |
| rtsOut | output | 1 | Request-to-send output, software driven |
| irqOut | output | 1 | Interrupt request |

## Verification
A received byte and free transmit space are both interrupt causes, and they routinely hold in the same cycle. The bench provokes this by receiving a frame while the transmit queue is empty, with both causes enabled. It then requires the identify register to show only the receive cause. Once the byte has been popped, it requires the transmit cause to appear, and irqOut to follow the two high enable bits. A second collision is a frame that completes against a full receive queue. There the bench judges that the ninth byte is lost, the overrun bit rises once, and the eight earlier bytes come out unchanged.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;

  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] RA_DATA = 4'd0;
  localparam logic [ADDR_W-1:0] RA_IEN  = 4'd1;
  localparam logic [ADDR_W-1:0] RA_IID  = 4'd2;
  localparam logic [ADDR_W-1:0] RA_LCTL = 4'd3;
  localparam logic [ADDR_W-1:0] RA_MCTL = 4'd4;
  localparam logic [ADDR_W-1:0] RA_LSTA = 4'd5;
  localparam logic [ADDR_W-1:0] RA_MSTA = 4'd6;
  localparam logic [ADDR_W-1:0] RA_SCR  = 4'd7;
  localparam logic [ADDR_W-1:0] RA_ENAB = 4'd8;
  localparam logic [ADDR_W-1:0] RA_DIV  = 4'd10;

  typedef enum logic [1:0] {LN_IDLE, LN_START, LN_DATA, LN_STOP} lineState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic rxFlush;
    logic txFlush;
    logic ovrClr;
  } dpCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic       rxAvail;
    logic       txSpace;
    logic       txIdle;
    logic       overrun;
    logic [7:0] rxByte;
  } dpStat_t;

endpackage

// File: rtl/lite_uart_fifo.sv
module lite_uart_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPop  = pop && !empty;
  assign doPush = push && (!full || doPop);
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !flush) mem[wrPtr] <= wrData;
  end

  // R4
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> empty);

endmodule

// File: rtl/lite_uart_dp.sv
module lite_uart_dp
  import lite_uart_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16,
  parameter int TPB   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  input  logic [7:0]       txByteIn,
  input  logic [DIV_W-1:0] baudDiv,
  input  logic             wide8,
  input  logic             rxEnable,
  input  logic             txEnable,
  input  logic             rxLine,
  output dpStat_t          stat,
  output logic             txLine
);
  localparam int TICK_W = (TPB > 1) ? $clog2(TPB) : 1;
  localparam int HALF   = TPB / 2;

  // ---------------- baud tick ----------------
  logic [DIV_W-1:0] divCnt, divLast;
  logic baudTick;

  assign divLast  = (baudDiv == '0) ? '0 : baudDiv - 1'b1;
  assign baudTick = (divCnt >= divLast);

  always_ff @(posedge clk) begin
    if (!rstN)         divCnt <= '0;
    else if (baudTick) divCnt <= '0;
    else               divCnt <= divCnt + 1'b1;
  end

  logic [2:0] bitLast;
  assign bitLast = wide8 ? 3'd7 : 3'd6;

  // ---------------- transmit ----------------
  lineState_t        txState;
  logic [TICK_W-1:0] txTicks;
  logic [2:0]        txBits;
  logic [7:0]        txShift;
  logic [7:0]        txHead;
  logic              txFull, txEmpty, txLoad, txBitEnd;

  assign txLoad   = (txState == LN_IDLE) && baudTick && txEnable && !txEmpty && !cmd.txFlush;
  assign txBitEnd = baudTick && (txTicks == TICK_W'(TPB - 1));

  lite_uart_fifo #(.DEPTH(DEPTH), .WIDTH(8)) txQueue (
    .clk(clk), .rstN(rstN), .push(cmd.txPush), .pop(txLoad), .flush(cmd.txFlush),
    .wrData(txByteIn), .rdData(txHead), .full(txFull), .empty(txEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= LN_IDLE;
      txTicks <= '0;
      txBits  <= '0;
      txShift <= '0;
      txLine  <= 1'b1;
    end else begin
      unique case (txState)
        LN_IDLE: if (txLoad) begin
          txState <= LN_START;
          txShift <= txHead;
          txTicks <= '0;
          txLine  <= 1'b0;
        end
        LN_START: begin
          if (txBitEnd) begin
            txState <= LN_DATA;
            txTicks <= '0;
            txBits  <= '0;
            txLine  <= txShift[0];
            txShift <= {1'b0, txShift[7:1]};
          end else if (baudTick) txTicks <= txTicks + 1'b1;
        end
        LN_DATA: begin
          if (txBitEnd) begin
            txTicks <= '0;
            if (txBits == bitLast) begin
              txState <= LN_STOP;
              txLine  <= 1'b1;
            end else begin
              txBits  <= txBits + 1'b1;
              txLine  <= txShift[0];
              txShift <= {1'b0, txShift[7:1]};
            end
          end else if (baudTick) txTicks <= txTicks + 1'b1;
        end
        LN_STOP: begin
          if (txBitEnd) begin
            txState <= LN_IDLE;
            txTicks <= '0;
          end else if (baudTick) txTicks <= txTicks + 1'b1;
        end
        default: txState <= LN_IDLE;
      endcase
    end
  end

  // R2
  tx_idle_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txState == LN_IDLE) |-> txLine);

  // ---------------- receive ----------------
  logic [1:0]        rxSync;
  logic              rxBit;
  lineState_t        rxState;
  logic [TICK_W-1:0] rxTicks;
  logic [2:0]        rxBits;
  logic [7:0]        rxShift, rxWord, rxHead;
  logic              rxFull, rxEmpty, rxPush, rxBitEnd, overrun;

  assign rxBit    = rxSync[1];
  assign rxBitEnd = baudTick && (rxTicks == TICK_W'(TPB - 1));
  assign rxPush   = (rxState == LN_STOP) && rxBitEnd && rxEnable;
  assign rxWord   = wide8 ? rxShift : {1'b0, rxShift[7:1]};

  always_ff @(posedge clk) begin
    if (!rstN) rxSync <= 2'b11;
    else       rxSync <= {rxSync[0], rxLine};
  end

  lite_uart_fifo #(.DEPTH(DEPTH), .WIDTH(8)) rxQueue (
    .clk(clk), .rstN(rstN), .push(rxPush), .pop(cmd.rxPop), .flush(cmd.rxFlush),
    .wrData(rxWord), .rdData(rxHead), .full(rxFull), .empty(rxEmpty)
  );

  always_ff @(posedge clk) begin
    if (!rstN || !rxEnable) begin
      rxState <= LN_IDLE;
      rxTicks <= '0;
      rxBits  <= '0;
      if (!rstN) rxShift <= '0;
    end else begin
      unique case (rxState)
        LN_IDLE: if (baudTick && !rxBit) begin
          rxState <= LN_START;
          rxTicks <= '0;
        end
        LN_START: if (baudTick) begin
          if (rxTicks == TICK_W'(HALF - 1)) begin
            rxTicks <= '0;
            rxBits  <= '0;
            rxState <= rxBit ? LN_IDLE : LN_DATA;
          end else rxTicks <= rxTicks + 1'b1;
        end
        LN_DATA: begin
          if (rxBitEnd) begin
            rxTicks <= '0;
            rxShift <= {rxBit, rxShift[7:1]};
            if (rxBits == bitLast) rxState <= LN_STOP;
            else                   rxBits  <= rxBits + 1'b1;
          end else if (baudTick) rxTicks <= rxTicks + 1'b1;
        end
        LN_STOP: begin
          if (rxBitEnd) begin
            rxState <= LN_IDLE;
            rxTicks <= '0;
          end else if (baudTick) rxTicks <= rxTicks + 1'b1;
        end
        default: rxState <= LN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) overrun <= 1'b0;
    else if (rxPush && rxFull && !cmd.rxPop && !cmd.rxFlush) overrun <= 1'b1;
    else if (cmd.ovrClr) overrun <= 1'b0;
  end

  // R5
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull));

  always_comb begin
    stat.rxAvail = !rxEmpty;
    stat.txSpace = !txFull;
    stat.txIdle  = txEmpty && (txState == LN_IDLE);
    stat.overrun = overrun;
    stat.rxByte  = rxEmpty ? 8'h00 : rxHead;
  end

endmodule

// File: rtl/lite_uart_ctrl.sv
module lite_uart_ctrl
  import lite_uart_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic              ctsIn,
  input  dpStat_t           stat,
  output dpCmd_t            cmd,
  output logic [7:0]        txByte,
  output logic [DIV_W-1:0]  baudDiv,
  output logic              wide8,
  output logic              rxEnable,
  output logic              txEnable,
  output logic              rtsOut,
  output logic              irqOut
);
  logic [3:0] ienReg;
  logic [1:0] lctlReg;
  logic [7:0] scratch;
  logic [1:0] ctsSync;
  logic       rxPend, txPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ienReg   <= '0;
      lctlReg  <= '0;
      scratch  <= '0;
      rtsOut   <= 1'b0;
      rxEnable <= 1'b0;
      txEnable <= 1'b0;
      baudDiv  <= '0;
      ctsSync  <= '0;
    end else begin
      ctsSync <= {ctsSync[0], ctsIn};
      if (regWrEn) begin
        unique case (regAddr)
          RA_IEN:  ienReg  <= regWrData[3:0];
          RA_LCTL: lctlReg <= regWrData[1:0];
          RA_MCTL: rtsOut  <= regWrData[1];
          RA_SCR:  scratch <= regWrData[7:0];
          RA_ENAB: {txEnable, rxEnable} <= regWrData[1:0];
          RA_DIV:  baudDiv <= regWrData[DIV_W-1:0];
          default: ;
        endcase
      end
    end
  end

  assign wide8  = (lctlReg == 2'b11);
  assign txByte = regWrData[7:0];

  always_comb begin
    cmd.txPush  = regWrEn && (regAddr == RA_DATA);
    cmd.rxPop   = regRdEn && (regAddr == RA_DATA) && stat.rxAvail;
    cmd.rxFlush = regWrEn && (regAddr == RA_IID) && regWrData[1];
    cmd.txFlush = regWrEn && (regAddr == RA_IID) && regWrData[2];
    cmd.ovrClr  = regRdEn && (regAddr == RA_LSTA);
  end

  assign rxPend = ienReg[0] && stat.rxAvail;
  assign txPend = ienReg[1] && stat.txSpace && !rxPend;
  assign irqOut = (rxPend || txPend) && ienReg[3] && ienReg[2];

  always_comb begin
    unique case (regAddr)
      RA_DATA: regRdData = BUS_W'(stat.rxByte);
      RA_IEN:  regRdData = BUS_W'(ienReg);
      RA_IID:  regRdData = BUS_W'({rxPend, txPend, !(rxPend || txPend)});
      RA_LCTL: regRdData = BUS_W'(lctlReg);
      RA_MCTL: regRdData = BUS_W'({rtsOut, 1'b0});
      RA_LSTA: regRdData = BUS_W'({stat.txIdle, stat.txSpace, 3'b000, stat.overrun, stat.rxAvail});
      RA_MSTA: regRdData = BUS_W'({ctsSync[1], 5'b00000});
      RA_SCR:  regRdData = BUS_W'(scratch);
      RA_ENAB: regRdData = BUS_W'({txEnable, rxEnable});
      RA_DIV:  regRdData = BUS_W'(baudDiv);
      default: regRdData = '0;
    endcase
  end

  // R6
  iid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxPend, txPend}));

  // R7
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (stat.rxAvail || stat.txSpace));

endmodule

// File: rtl/lite_uart.sv
module lite_uart
  import lite_uart_pkg::*;
#(
  parameter int BUS_W = 16,
  parameter int DIV_W = 16,
  parameter int DEPTH = 8,
  parameter int TPB   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  input  logic              rxIn,
  output logic              txOut,
  input  logic              ctsIn,
  output logic              rtsOut,
  output logic              irqOut
);
  dpCmd_t           cmd;
  dpStat_t          stat;
  logic [7:0]       txByte;
  logic [DIV_W-1:0] baudDiv;
  logic             wide8, rxEnable, txEnable;

  lite_uart_ctrl #(.BUS_W(BUS_W), .DIV_W(DIV_W)) ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .ctsIn(ctsIn), .stat(stat),
    .cmd(cmd), .txByte(txByte), .baudDiv(baudDiv), .wide8(wide8),
    .rxEnable(rxEnable), .txEnable(txEnable), .rtsOut(rtsOut), .irqOut(irqOut)
  );

  lite_uart_dp #(.DEPTH(DEPTH), .DIV_W(DIV_W), .TPB(TPB)) dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .txByteIn(txByte), .baudDiv(baudDiv),
    .wide8(wide8), .rxEnable(rxEnable), .txEnable(txEnable), .rxLine(rxIn),
    .stat(stat), .txLine(txOut)
  );

endmodule

// File: tb/lite_uart_test.sv
module lite_uart_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        rxIn = 1'b1;
  logic        txOut;
  logic        ctsIn = 1'b0;
  logic        rtsOut;
  logic        irqOut;

  int nChecks = 0;
  int nFails  = 0;
  bit summaryDone = 1'b0;

  always #2.5 clk = ~clk;

  lite_uart uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .rxIn(rxIn), .txOut(txOut),
    .ctsIn(ctsIn), .rtsOut(rtsOut), .irqOut(irqOut)
  );

  typedef struct packed {
    logic       wl8;
    logic [7:0] din;
    logic [7:0] dexp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b1, 8'h55, 8'h55},
    '{1'b1, 8'hA3, 8'hA3},
    '{1'b1, 8'h00, 8'h00},
    '{1'b1, 8'hFF, 8'hFF},
    '{1'b0, 8'hC5, 8'h45},
    '{1'b0, 8'h3A, 8'h3A}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic sendFrame(input logic [7:0] b, input int nbits, input int cpb);
    @(negedge clk);
    rxIn = 1'b0;
    repeat (cpb) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxIn = b[i];
      repeat (cpb) @(negedge clk);
    end
    rxIn = 1'b1;
    repeat (cpb) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic grabFrame(input int nbits, input int cpb, output logic [7:0] got,
                           output logic startOk, output logic stopOk);
    int guard = 0;
    got = '0;
    while (txOut !== 1'b0 && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    repeat (cpb / 2) @(negedge clk);
    startOk = (txOut === 1'b0);
    for (int i = 0; i < nbits; i++) begin
      repeat (cpb) @(negedge clk);
      got[i] = txOut;
    end
    repeat (cpb) @(negedge clk);
    stopOk = (txOut === 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
    summary();
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  got;
    logic        sOk, pOk, sawLow;
    int          cpb;

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(4'd5, v); chk("R1 line status", v, 16'h0060);
    rd(4'd2, v); chk("R1 identify", v, 16'h0001);
    chk("R1 txOut", {15'd0, txOut}, 16'd1);
    chk("R1 rtsOut", {15'd0, rtsOut}, 16'd0);
    chk("R1 irqOut", {15'd0, irqOut}, 16'd0);
    rd(4'd8, v); chk("R1 enables", v, 16'h0000);

    wr(4'd10, 16'd2);
    wr(4'd8, 16'h0003);
    cpb = 16;

    // table walk: R2 transmit, R3 receive
    foreach (VECS[k]) begin
      int nb;
      nb = VECS[k].wl8 ? 8 : 7;
      wr(4'd3, VECS[k].wl8 ? 16'h0003 : 16'h0000);
      sendFrame(VECS[k].din, nb, cpb);
      rd(4'd5, v); chk("R3 data ready", {15'd0, v[0]}, 16'd1);
      rd(4'd0, v); chk("R3 received byte", v, {8'd0, VECS[k].dexp});
      wr(4'd0, {8'd0, VECS[k].din});
      grabFrame(nb, cpb, got, sOk, pOk);
      chk("R2 start bit", {15'd0, sOk}, 16'd1);
      chk("R2 data bits", {8'd0, got}, {8'd0, VECS[k].dexp});
      chk("R2 stop bit", {15'd0, pOk}, 16'd1);
    end
    rd(4'd0, v); chk("R3 empty read", v, 16'h0000);

    // R10 registers
    wr(4'd7, 16'h00A5); rd(4'd7, v); chk("R10 scratch", v, 16'h00A5);
    wr(4'd4, 16'h00FF); rd(4'd4, v); chk("R10 mctl readback", v, 16'h0002);
    chk("R10 rtsOut", {15'd0, rtsOut}, 16'd1);
    wr(4'd4, 16'h0000); chk("R10 rtsOut low", {15'd0, rtsOut}, 16'd0);
    ctsIn = 1'b1; repeat (3) @(negedge clk);
    rd(4'd6, v); chk("R10 cts high", v, 16'h0020);
    ctsIn = 1'b0; repeat (3) @(negedge clk);
    rd(4'd6, v); chk("R10 cts low", v, 16'h0000);
    wr(4'd1, 16'h00FF); rd(4'd1, v); chk("R10 ien readback", v, 16'h000F);
    wr(4'd1, 16'h0000);
    wr(4'd3, 16'h00FF); rd(4'd3, v); chk("R10 lctl readback", v, 16'h0003);

    // R12 divisor
    wr(4'd10, 16'hBEEF); rd(4'd10, v); chk("R12 divisor readback", v, 16'hBEEF);
    wr(4'd10, 16'd3);
    wr(4'd0, 16'h00C3);
    grabFrame(8, 24, got, sOk, pOk);
    chk("R12 divisor 3 data", {8'd0, got}, 16'h00C3);
    chk("R12 divisor 3 stop", {15'd0, pOk}, 16'd1);
    wr(4'd10, 16'd0);
    wr(4'd0, 16'h005A);
    grabFrame(8, 8, got, sOk, pOk);
    chk("R12 divisor 0 as 1", {8'd0, got}, 16'h005A);
    wr(4'd10, 16'd2);
    repeat (40) @(negedge clk);

    // R4 / R11 / R9: queue with transmitter off
    wr(4'd8, 16'h0001);
    for (int i = 0; i < 7; i++) wr(4'd0, 16'(8'h30 + i));
    rd(4'd5, v); chk("R4 space after 7", {15'd0, v[5]}, 16'd1);
    wr(4'd0, 16'h0037);
    rd(4'd5, v); chk("R4 full after 8", {15'd0, v[5]}, 16'd0);
    chk("R9 not idle with queued bytes", {15'd0, v[6]}, 16'd0);
    sawLow = 1'b0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (txOut !== 1'b1) sawLow = 1'b1;
    end
    chk("R11 transmitter off holds line", {15'd0, sawLow}, 16'd0);
    wr(4'd8, 16'h0003);
    for (int i = 0; i < 8; i++) begin
      grabFrame(8, cpb, got, sOk, pOk);
      chk("R4 order", {8'd0, got}, 16'(8'h30 + i));
    end
    repeat (40) @(negedge clk);
    rd(4'd5, v); chk("R9 idle after drain", v, 16'h0060);

    // R9 shifter busy with empty queue
    wr(4'd0, 16'h0011);
    repeat (10) @(negedge clk);
    rd(4'd5, v); chk("R9 busy shifter", v & 16'h0060, 16'h0020);
    grabFrame(8, cpb, got, sOk, pOk);
    repeat (40) @(negedge clk);

    // R8 flush
    wr(4'd8, 16'h0001);
    wr(4'd0, 16'h0001); wr(4'd0, 16'h0002); wr(4'd0, 16'h0003);
    wr(4'd2, 16'h0004);
    rd(4'd5, v); chk("R8 tx flush", v, 16'h0060);
    wr(4'd8, 16'h0003);
    sawLow = 1'b0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (txOut !== 1'b1) sawLow = 1'b1;
    end
    chk("R8 flushed bytes not sent", {15'd0, sawLow}, 16'd0);
    sendFrame(8'h21, 8, cpb);
    sendFrame(8'h22, 8, cpb);
    rd(4'd5, v); chk("R8 rx before flush", {15'd0, v[0]}, 16'd1);
    wr(4'd2, 16'h0002);
    rd(4'd5, v); chk("R8 rx flush", {15'd0, v[0]}, 16'd0);
    rd(4'd0, v); chk("R8 rx flushed read", v, 16'h0000);

    // R5 overrun
    for (int i = 0; i < 9; i++) sendFrame(8'h90 + 8'(i), 8, cpb);
    rd(4'd5, v); chk("R5 overrun set", v, 16'h0063);
    rd(4'd5, v); chk("R5 overrun cleared", v, 16'h0061);
    for (int i = 0; i < 8; i++) begin
      rd(4'd0, v); chk("R5 kept bytes", v, 16'(8'h90 + i));
    end
    rd(4'd5, v); chk("R5 ninth dropped", {15'd0, v[0]}, 16'd0);

    // R6 / R7 priority, both causes in the same cycle
    wr(4'd1, 16'h0003);
    sendFrame(8'h6B, 8, cpb);
    rd(4'd2, v); chk("R6 receive wins", v, 16'h0004);
    chk("R7 no irq without bits 2,3", {15'd0, irqOut}, 16'd0);
    wr(4'd1, 16'h000F);
    chk("R7 irq with bits 2,3", {15'd0, irqOut}, 16'd1);
    rd(4'd0, v); chk("R3 byte during priority", v, 16'h006B);
    rd(4'd2, v); chk("R6 transmit after drain", v, 16'h0002);
    chk("R7 irq tx cause", {15'd0, irqOut}, 16'd1);
    wr(4'd1, 16'h000D);
    rd(4'd2, v); chk("R6 none pending", v, 16'h0001);
    chk("R7 irq off", {15'd0, irqOut}, 16'd0);
    wr(4'd1, 16'h0000);

    // R11 receiver off
    wr(4'd8, 16'h0002);
    sendFrame(8'h77, 8, cpb);
    rd(4'd5, v); chk("R11 receiver off ignores", {15'd0, v[0]}, 16'd0);

    summary();
  end

endmodule